// File: doc/BRIEF.md
# Demand-Driven Two-Road Traffic Light Controller

This block is a Moore state machine that controls the green and red lights where a north-south road crosses an east-west road. Each road has a car detector input, and each road has a light-enable output: high means green, low means red. Green is handed to the other road only when that road's detector reports a waiting car. When nobody waits on the other road, the current green stays.

A dwell timer limits how often the lights can change. A free-running counter emits a one-cycle step pulse every `DWELL_CYCLES` clocks, and the state may change only on that pulse. The default counts 30 seconds at a 50 MHz clock. The reset input is asynchronous and active-low. It clears the block at once and is released through a two-flop synchronizer.

Top module: `traffic_light_ctrl`

## Requirements
- R1: While reset is applied and right after it is released, the north-south light is green (`ns_green`=1) and the east-west light is red (`ew_green`=0). The state is encoded in one bit: north-south green = 0, east-west green = 1.
- R2: In every cycle, exactly one of `ns_green` and `ew_green` is high.
- R3: With north-south green, a step pulse while `ew_car`=1 turns east-west green at that clock edge, whatever the value of `ns_car`.
- R4: With east-west green, a step pulse while `ns_car`=1 turns north-south green at that clock edge, whatever the value of `ew_car`.
- R5: When the road that is red reports no car, the green stays where it is, even if the green road's own detector is active.
- R6: Two light changes are never closer than `DWELL_CYCLES` clocks apart. With demand held on both roads, the lights swap exactly every `DWELL_CYCLES` clocks.
- R7: Pulling `rst_n` low forces north-south green at once, without waiting for a clock edge.
- R8: After `rst_n` rises, the internal reset lifts on the second rising edge. The dwell count then starts from zero, so with east-west demand present the first change lands on the (`DWELL_CYCLES`+2)-th rising edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ns_car | input | 1 | Car detected on the north-south road |
| ew_car | input | 1 | Car detected on the east-west road |
| ns_green | output | 1 | North-south light green when high, red when low |
| ew_green | output | 1 | East-west light green when high, red when low |

## Verification
The bench builds the controller with `DWELL_CYCLES` = 4 instead of the full 30-second count. This makes each dwell period short enough to cover many handovers, held-green periods and demand on both roads in a few hundred cycles. With this value, the exact swap period under demand on both roads can be measured, and the exact cycle of the first change after reset release can be predicted and checked. Each stimulus vector is held for one full dwell period, so it covers exactly one step pulse no matter where the counter's phase lies.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  typedef enum logic {
    GREEN_NS = 1'b0,
    GREEN_EW = 1'b1
  } light_state_e;
endpackage

// File: rtl/tlc_rst_sync.sv
module tlc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/tlc_dwell_timer.sv
module tlc_dwell_timer #(
  parameter int unsigned DWELL_CYCLES = 32'd1_500_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic step
);
  localparam int unsigned CNT_W = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign step    = at_last;

  always_comb begin
    if (at_last) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // After a step the count restarts, so the next step is a full period away.
  p_wrap_after_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q == '0));
endmodule

// File: rtl/tlc_light_fsm.sv
module tlc_light_fsm
  import tlc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic ns_car,
  input  logic ew_car,
  output logic ns_green,
  output logic ew_green
);
  light_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (step) begin
      unique case (state_q)
        GREEN_NS: if (ew_car) state_d = GREEN_EW;
        GREEN_EW: if (ns_car) state_d = GREEN_NS;
        default:  state_d = GREEN_NS;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GREEN_NS;
    else        state_q <= state_d;
  end

  assign ns_green = (state_q == GREEN_NS);
  assign ew_green = (state_q == GREEN_EW);

  p_to_ew_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ns_green && ew_car) |=> ew_green);
  p_to_ns_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ew_green && ns_car) |=> ns_green);
  p_hold_ns_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_green && !ew_car) |=> ns_green);
  p_hold_ew_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ew_green && !ns_car) |=> ew_green);
  p_change_on_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ew_green != $past(ew_green)) |-> $past(step));
endmodule

// File: rtl/traffic_light_ctrl.sv
module traffic_light_ctrl #(
  parameter int unsigned DWELL_CYCLES = 32'd1_500_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ns_car,
  input  logic ew_car,
  output logic ns_green,
  output logic ew_green
);
  logic rst_n_int;
  logic step;

  tlc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  tlc_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n_int),
    .step  (step)
  );

  tlc_light_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .step     (step),
    .ns_car   (ns_car),
    .ew_car   (ew_car),
    .ns_green (ns_green),
    .ew_green (ew_green)
  );

  // Checked at the ports, from the timer and FSM outputs together.
  p_one_light_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    $countones({ns_green, ew_green}) == 1);
endmodule

// File: tb/traffic_light_ctrl_tb.sv
module traffic_light_ctrl_tb;
  localparam int unsigned D = 4;
  localparam int NVEC = 10;
  // each entry: {ns_car, ew_car, expected ew_green after one dwell period, req}
  typedef struct packed { logic ns; logic ew; logic exp_ew; logic [3:0] req; } vec_t;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 4'd5},  // R5 no demand
    '{1'b1, 1'b0, 1'b0, 4'd5},  // R5 own-road car only
    '{1'b0, 1'b1, 1'b1, 4'd3},  // R3 handover to east-west
    '{1'b0, 1'b1, 1'b1, 4'd5},  // R5 east-west own car only
    '{1'b0, 1'b0, 1'b1, 4'd5},  // R5 idle
    '{1'b1, 1'b1, 1'b0, 4'd4},  // R4 with ew_car also set
    '{1'b1, 1'b1, 1'b1, 4'd3},  // R3 with ns_car also set
    '{1'b1, 1'b0, 1'b0, 4'd4},  // R4
    '{1'b0, 1'b0, 1'b0, 4'd5},  // R5
    '{1'b1, 1'b1, 1'b1, 4'd3}   // R3
  };

  logic clk = 1'b0, rst_n = 1'b0, ns_car = 1'b0, ew_car = 1'b0;
  logic ns_green, ew_green;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  traffic_light_ctrl #(.DWELL_CYCLES(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .ns_car(ns_car), .ew_car(ew_car),
    .ns_green(ns_green), .ew_green(ew_green)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    int changes;
    int gap;
    logic prev;
    @(negedge clk); @(negedge clk);
    check(ns_green == 1'b1 && ew_green == 1'b0, "R1", {ns_green, ew_green}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check(ns_green == 1'b1 && ew_green == 1'b0, "R1", {ns_green, ew_green}, 2'b10);

    for (int i = 0; i < NVEC; i++) begin
      ns_car = VECS[i].ns; ew_car = VECS[i].ew;
      changes = 0; prev = ew_green;
      for (int k = 0; k < int'(D); k++) begin
        @(negedge clk);
        if (ew_green != prev) changes++;
        prev = ew_green;
        if ((ns_green ^ ew_green) !== 1'b1) check(1'b0, "R2", {ns_green, ew_green}, 1);
      end
      check(ew_green == VECS[i].exp_ew, $sformatf("R%0d vec%0d", VECS[i].req, i),
            ew_green, VECS[i].exp_ew);
      check(changes <= 1, "R6 one change per window", changes, 1);
      check((ns_green ^ ew_green) == 1'b1, "R2", {ns_green, ew_green}, 1);
    end

    // R6: exact swap period with demand on both roads
    ns_car = 1'b1; ew_car = 1'b1;
    prev = ew_green;
    while (ew_green == prev) @(negedge clk);
    for (int n = 0; n < 2; n++) begin
      prev = ew_green; gap = 0;
      while (ew_green == prev && gap < 100) begin @(negedge clk); gap++; end
      check(gap == int'(D), "R6 swap period", gap, D);
    end

    // R7: async reset with east-west green
    while (ew_green != 1'b1) @(negedge clk);
    #3 rst_n = 1'b0;
    #1 check(ns_green == 1'b1 && ew_green == 1'b0, "R7", {ns_green, ew_green}, 2'b10);
    ns_car = 1'b0; ew_car = 1'b1;
    @(negedge clk); @(negedge clk);
    check(ns_green == 1'b1, "R1 held in reset", ns_green, 1);

    // R8: release timing; change on edge D+2 after rst_n rises
    rst_n = 1'b1;
    for (int e = 1; e <= int'(D) + 1; e++) @(negedge clk);
    check(ew_green == 1'b0, "R8 before first step", ew_green, 0);
    @(negedge clk);
    check(ew_green == 1'b1, "R8 first change", ew_green, 1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); check(1'b0, "watchdog", 0, 1); end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule